// File: doc/BRIEF.md
# Center-Aligned Four-Channel PWM Generator

This block drives four pulse-width outputs from one shared time base. The time base is a 12-bit counter that climbs from zero to the active period value, reverses, and descends back to zero. As a result, every channel's pulse is symmetric about the peak of the count. Each channel compares the count against its own duty value. It holds its active level while the count is below that value and its inactive level otherwise. The outputs therefore switch on an upward match and switch back on the matching downward count.

Software writes the period and the four duty values into holding registers through a simple write strobe. It then sets a load request. The holding values move into the active registers only at the bottom of the count, in the cycle the counter returns to zero, and only if the load request is set. This means a running cycle is never disturbed. The same event produces a one-cycle interrupt pulse. A polarity input selects which logic level counts as active. Dropping the enable input returns the block to its reset state.

Top module: `cpwm_top`

## Requirements
- R1: The counter starts at 0, never exceeds the active period P, and with P = 0 it holds at 0 and every cycle counts as an underflow.
- R2: On reaching P while rising, the counter turns to falling, and it turns back to rising on reaching 0. The sequence is 0,1..P,P-1..1,0, so interrupts are 2P cycles apart (2 cycles for P = 1).
- R3: Channel i is active while the count is below its active duty D (0 < D < P) and inactive otherwise. The active level equals pol_i and the inactive level is its complement. Outputs are registered and reflect the count held in the same cycle.
- R4: A nonzero duty value at or above P keeps the channel active for the whole cycle.
- R5: A duty value of 0 keeps the channel inactive for the whole cycle.
- R6: Register writes go to holding registers (address 0 = period, addresses 1 to 4 = duty of channels 0 to 3, addresses 6 and 7 do nothing). Holding values reach the active registers only at an underflow while the load request is set, and never otherwise.
- R7: A write to address 5 with wdata_i[0] = 1 sets the load request, shown on load_pend_o. The request clears at the edge where the copy takes place, unless a new set arrives in that same cycle.
- R8: irq_o is high for exactly one cycle per underflow: the cycle in which the counter shows 0 after its descent.
- R9: While en_i is low, the counter, active registers, holding registers, load request and interrupt are cleared, writes are ignored, and all outputs sit at the inactive level.
- R10: After reset, irq_o and load_pend_o are 0 and every pwm_o bit equals the complement of pol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the block |
| pol_i | input | 1 | Active output level |
| wr_i | input | 1 | Register write strobe |
| waddr_i | input | 3 | Register address |
| wdata_i | input | 12 | Register write data |
| pwm_o | output | 4 | Channel outputs |
| irq_o | output | 1 | Underflow interrupt pulse |
| load_pend_o | output | 1 | Load request still pending |

## Verification
The hardest situation to reach is a write or a load request that lands in the very cycle of an underflow. In that cycle the old holding value is copied while the new one is stored, and a new set competes with the automatic clear. Short periods (0, 1, 2) make underflows frequent, so the random phase draws periods mostly from a small range and issues writes on many cycles. This makes such collisions common. A per-cycle reference model tracks the outputs, the interrupt and the pending flag through every one of these collisions.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CNT_W     = 12;
  localparam int NCH       = 4;
  localparam int ADDR_W    = 3;
  localparam int A_PER     = 0;
  localparam int A_DUTY0   = 1;
  localparam int A_LOAD    = 5;
endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int W = cpwm_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d, uf;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    uf    = 1'b0;
    if (!en_i) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (per_i == '0) begin
      cnt_d = '0;
      dn_d  = 1'b0;
      uf    = 1'b1;
    end else if (!dn_q) begin
      if (cnt_q >= per_i) begin
        cnt_d = per_i - 1'b1;
        dn_d  = (per_i != W'(1));
        uf    = (per_i == W'(1));
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == W'(1)) begin
        dn_d = 1'b0;
        uf   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign uf_o      = uf;

  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= per_i);
  a_r2_peak_reverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !dn_q && per_i > W'(1) && cnt_q == per_i |=> dn_q || !$past(en_i) || cnt_q == '0);
  a_r2_bottom_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dn_q && cnt_q == W'(1) |=> !dn_q && cnt_q == '0);
endmodule

// File: rtl/cpwm_regs.sv
module cpwm_regs #(
  parameter int W   = cpwm_pkg::CNT_W,
  parameter int N   = cpwm_pkg::NCH,
  parameter int AW  = cpwm_pkg::ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                wr_i,
  input  logic [AW-1:0]       waddr_i,
  input  logic [W-1:0]        wdata_i,
  input  logic                uf_i,
  output logic [W-1:0]        per_o,
  output logic [W-1:0]        per_nxt_o,
  output logic [N-1:0][W-1:0] duty_o,
  output logic [N-1:0][W-1:0] duty_nxt_o,
  output logic                load_o
);
  localparam logic [AW-1:0] PER_A  = AW'(cpwm_pkg::A_PER);
  localparam logic [AW-1:0] LOAD_A = AW'(cpwm_pkg::A_LOAD);

  logic [W-1:0]        per_hold_q, per_act_q;
  logic [N-1:0][W-1:0] duty_hold_q, duty_act_q;
  logic                load_q, set_w, xfer;

  assign set_w = wr_i && waddr_i == LOAD_A && wdata_i[0];
  assign xfer  = uf_i && load_q;

  // next active values, fed to the output stage so outputs align with state
  always_comb begin
    per_nxt_o  = !en_i ? '0 : xfer ? per_hold_q  : per_act_q;
    duty_nxt_o = !en_i ? '0 : xfer ? duty_hold_q : duty_act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_hold_q  <= '0;
      duty_hold_q <= '0;
      load_q      <= 1'b0;
    end else if (!en_i) begin
      per_hold_q  <= '0;
      duty_hold_q <= '0;
      load_q      <= 1'b0;
    end else begin
      if (wr_i && waddr_i == PER_A) per_hold_q <= wdata_i;
      for (int i = 0; i < N; i++)
        if (wr_i && waddr_i == AW'(cpwm_pkg::A_DUTY0 + i)) duty_hold_q[i] <= wdata_i;
      if (set_w)     load_q <= 1'b1;
      else if (xfer) load_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_act_q  <= '0;
      duty_act_q <= '0;
    end else begin
      per_act_q  <= per_nxt_o;
      duty_act_q <= duty_nxt_o;
    end
  end

  assign per_o  = per_act_q;
  assign duty_o = duty_act_q;
  assign load_o = load_q;

  a_r6_hold_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !(uf_i && load_q) |=> $stable(per_act_q) && $stable(duty_act_q));
  a_r7_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q && uf_i && !set_w |=> !load_q);
  a_r9_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> per_hold_q == '0 && !load_q && per_act_q == '0);
endmodule

// File: rtl/cpwm_chan.sv
module cpwm_chan #(
  parameter int W = cpwm_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] per_nxt_i,
  input  logic [W-1:0] duty_nxt_i,
  input  logic         pol_i,
  output logic         act_o,
  output logic         pwm_o
);
  logic act_q, act_d;

  assign act_d = (duty_nxt_i != '0) && (duty_nxt_i >= per_nxt_i || cnt_nxt_i < duty_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_d;
  end

  assign act_o = act_q;
  assign pwm_o = act_q ? pol_i : ~pol_i;
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top #(
  parameter int W  = cpwm_pkg::CNT_W,
  parameter int N  = cpwm_pkg::NCH,
  parameter int AW = cpwm_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pol_i,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [N-1:0]  pwm_o,
  output logic          irq_o,
  output logic          load_pend_o
);
  logic [W-1:0]        cnt, cnt_nxt, per, per_nxt;
  logic [N-1:0][W-1:0] duty, duty_nxt;
  logic [N-1:0]        act;
  logic                uf, irq_q;

  cpwm_timebase #(.W(W)) u_tb (
    .clk_i, .rst_ni, .en_i, .per_i(per),
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .uf_o(uf)
  );

  cpwm_regs #(.W(W), .N(N), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .en_i, .wr_i, .waddr_i, .wdata_i, .uf_i(uf),
    .per_o(per), .per_nxt_o(per_nxt), .duty_o(duty), .duty_nxt_o(duty_nxt),
    .load_o(load_pend_o)
  );

  for (genvar g = 0; g < N; g++) begin : g_ch
    cpwm_chan #(.W(W)) u_ch (
      .clk_i, .rst_ni, .cnt_nxt_i(cnt_nxt), .per_nxt_i(per_nxt),
      .duty_nxt_i(duty_nxt[g]), .pol_i, .act_o(act[g]), .pwm_o(pwm_o[g])
    );
    a_r5_zero_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      duty[g] == '0 |-> !act[g]);
    a_r4_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      duty[g] != '0 && duty[g] >= per |-> act[g]);
    a_r3_low_count_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      duty[g] != '0 && cnt < duty[g] |-> act[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= uf;
  end
  assign irq_o = irq_q;

  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && per != '0 |=> !irq_q);
  a_r8_irq_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> cnt == '0);
endmodule

// File: tb/cpwm_top_bench.sv
module cpwm_top_bench;
  localparam int W = 12;
  localparam int N = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          en_i = 1'b0;
  logic          pol_i = 1'b1;
  logic          wr_i = 1'b0;
  logic [2:0]    waddr_i = '0;
  logic [W-1:0]  wdata_i = '0;
  logic [N-1:0]  pwm_o;
  logic          irq_o, load_pend_o;

  cpwm_top u_cpwm_top (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur = "R3";

  int m_cnt, m_dn, m_per, h_per, m_load, m_irq;
  int m_duty[N], h_duty[N], m_act[N];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_dn = 0; m_per = 0; h_per = 0; m_load = 0; m_irq = 0;
    for (int i = 0; i < N; i++) begin m_duty[i] = 0; h_duty[i] = 0; m_act[i] = 0; end
  endtask

  task automatic model_step();
    int cn, dn, uf, xf, st;
    if (!rst_ni || !en_i) begin model_clear(); return; end
    cn = m_cnt; dn = m_dn; uf = 0;
    if (m_per == 0) begin cn = 0; dn = 0; uf = 1; end
    else if (m_dn == 0) begin
      if (m_cnt >= m_per) begin cn = m_per - 1; dn = (m_per != 1); uf = (m_per == 1); end
      else cn = m_cnt + 1;
    end else begin
      cn = m_cnt - 1;
      if (m_cnt == 1) begin dn = 0; uf = 1; end
    end
    xf = uf && m_load;
    st = wr_i && waddr_i == 3'd5 && wdata_i[0];
    if (xf) begin
      m_per = h_per;
      for (int i = 0; i < N; i++) m_duty[i] = h_duty[i];
    end
    if (wr_i && waddr_i == 3'd0) h_per = int'(wdata_i);
    for (int i = 0; i < N; i++) if (wr_i && int'(waddr_i) == i + 1) h_duty[i] = int'(wdata_i);
    m_load = st ? 1 : (xf ? 0 : m_load);
    m_cnt = cn; m_dn = dn; m_irq = uf;
    for (int i = 0; i < N; i++)
      m_act[i] = (m_duty[i] != 0) && (m_duty[i] >= m_per || m_cnt < m_duty[i]);
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    #1;
    for (int i = 0; i < N; i++)
      chk(pwm_o[i] == (m_act[i] ? pol_i : !pol_i), cur, $sformatf("pwm%0d", i),
          int'(pwm_o[i]), int'(m_act[i] ? pol_i : !pol_i));
    chk(irq_o == m_irq[0], "R8", "irq", int'(irq_o), m_irq);
    chk(load_pend_o == m_load[0], "R7", "load_pend", int'(load_pend_o), m_load);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic wr(int a, int d);
    wr_i = 1'b1; waddr_i = 3'(a); wdata_i = W'(d);
    cyc();
    wr_i = 1'b0;
  endtask

  task automatic irq_gap(int exp, string req);
    int n;
    n = 0;
    while (!irq_o && n < 5000) begin cyc(); n++; end
    n = 0;
    do begin cyc(); n++; end while (!irq_o && n < 5000);
    chk(n == exp, req, "irq spacing", n, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    model_clear();
    #1;
    // R10 reset state
    cur = "R10";
    chk(pwm_o == ~{N{pol_i}}, "R10", "pwm after reset", int'(pwm_o), int'(~{N{pol_i}} & 4'hf));
    chk(irq_o == 1'b0 && load_pend_o == 1'b0, "R10", "irq/load after reset",
        int'({irq_o, load_pend_o}), 0);
    #4 rst_ni = 1'b1;
    run(3);

    // R1 enable with period 0: counter pinned, underflow each cycle
    en_i = 1'b1;
    cur = "R1";
    run(4);
    chk(irq_o == 1'b1, "R1", "irq held with P=0", int'(irq_o), 1);

    // R6 writes without load do nothing
    cur = "R6";
    wr(0, 10); wr(1, 0); wr(2, 3); wr(3, 10); wr(4, 12);
    run(8);
    chk(pwm_o == ~{N{pol_i}}, "R6", "outputs before load", int'(pwm_o), int'(~{N{pol_i}} & 4'hf));

    // R7 load then transfer; R5 ch0, R3 ch1, R4 ch2/ch3
    cur = "R3";
    wr(5, 1);
    run(3);
    chk(load_pend_o == 1'b0, "R7", "load cleared after copy", int'(load_pend_o), 0);
    cur = "R4";
    run(45);
    cur = "R2";
    irq_gap(20, "R2");

    // mid-cycle duty change: held until the next bottom
    cur = "R6";
    run(7);
    wr(2, 7); wr(1, 5);
    run(4);
    wr(5, 1);
    chk(load_pend_o == 1'b1, "R7", "load pending mid-cycle", int'(load_pend_o), 1);
    run(50);

    // P=1 and polarity flip
    cur = "R2";
    pol_i = 1'b0;
    wr(0, 1); wr(5, 1);
    run(25);
    irq_gap(2, "R2");

    // R9 disable clears, writes ignored
    cur = "R9";
    en_i = 1'b0;
    wr(0, 20); wr(5, 1);
    run(2);
    chk(pwm_o == ~{N{pol_i}} && !irq_o && !load_pend_o, "R9", "idle state",
        int'({pwm_o, irq_o, load_pend_o}), int'({~{N{pol_i}}, 2'b00}));
    en_i = 1'b1;
    run(2);
    chk(irq_o == 1'b1, "R9", "period cleared by disable", int'(irq_o), 1);

    // constrained random phase
    cur = "R3";
    for (int k = 0; k < 20000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) begin
        wr_i = 1'b1;
        waddr_i = 3'($urandom_range(0, 7));
        wdata_i = (waddr_i == 3'd0)
          ? W'(($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : $urandom_range(0, 30))
          : W'($urandom_range(0, 34));
        if (waddr_i == 3'd5) wdata_i[0] = ($urandom_range(0, 2) != 0);
      end else begin
        wr_i = 1'b0;
      end
      if (r == 99) pol_i = ~pol_i;
      en_i = ($urandom_range(0, 999) != 0);
      cyc();
    end
    wr_i = 1'b0; en_i = 1'b1;
    run(10);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule